// File: doc/BRIEF.md
# Load-Store Queue with Out-of-Order Completion Tracking

This block sits between the execute stage of an in-order core and the data memory. Execute pushes each load or store with a small request id. The operation waits in a pending queue until the translation unit reports that the address of the oldest pending entry is ready. A translated load then goes to memory and moves into an in-flight queue. A translated store needs no memory access before commit, so it moves straight into the in-flight queue already complete. A load whose address matches a store that has committed but not yet been written takes that store's data and never reaches memory.

Memory may answer loads in any order. Each answer carries the request id, and the in-flight queue finds the matching entry by comparing that id against all of its slots. It marks the entry complete but leaves it in place. Commit asks only about the oldest in-flight entry. It gets a hit, with the load data, only when the id it names matches that entry and the entry is complete. A committed store goes into a write buffer, which drains to memory oldest first over the same request port. Loads and buffered writes share that port under a burst limit on consecutive writes.

Top module: `ldst_queue`

## Requirements
- R1: After reset, `push_ready` is 1, `mreq_valid` is 0 and `cmt_hit` is 0 for any query.
- R2: A push is refused (`push_ready` = 0) while the pending queue holds RQ_DEPTH entries, and a refused push adds nothing.
- R3: The oldest pending entry takes no action until `xlate_done` has been seen while it is the oldest. A pulse of `xlate_done` while the pending queue is empty is ignored.
- R4: A translated load at the pending head with no write-buffer match raises `mreq_valid` with `mreq_store` = 0, its id and its address. It moves to the in-flight queue in the cycle `mreq_ready` accepts it. No move happens while the in-flight queue holds XQ_DEPTH entries.
- R5: A response (`mrsp_valid`, `mrsp_id`, `mrsp_data`) marks the in-flight load with that id complete, in any order. Commit then gets `cmt_hit` = 1 and `cmt_data` equal to the response data.
- R6: `cmt_hit` is 1 only if `cmt_id` equals the id of the oldest in-flight entry and that entry is complete. A query naming any other entry returns 0 and removes nothing.
- R7: A translated store moves to the in-flight queue complete, without a memory request. A commit hit on a store moves its address and data into the write buffer. That hit is refused while the write buffer holds SB_DEPTH entries.
- R8: The write buffer issues writes oldest first, with `mreq_store` = 1 and the buffered address and data. `mreq_id` carries no meaning for writes.
- R9: A translated load whose address equals the address of a buffered write completes without a memory request. Its data comes from the most recently buffered write to that address.
- R10: Buffered writes have priority on the memory port. Once SB_LIMIT writes have been accepted since the last load was sent, a waiting load gets the next grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | New operation from execute |
| push_ready | output | 1 | Pending queue can take a push |
| push_id | input | ID_W | Request id |
| push_store | input | 1 | 1 = store, 0 = load |
| push_addr | input | ADDR_W | Operation address |
| push_data | input | DATA_W | Store data |
| xlate_done | input | 1 | Translation finished for the oldest pending entry |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_id | output | ID_W | Id of a load request |
| mreq_store | output | 1 | 1 = buffered write, 0 = load |
| mreq_addr | output | ADDR_W | Request address |
| mreq_data | output | DATA_W | Write data |
| mrsp_valid | input | 1 | Load response valid |
| mrsp_id | input | ID_W | Id of the answered load |
| mrsp_data | input | DATA_W | Load data |
| cmt_valid | input | 1 | Commit query |
| cmt_id | input | ID_W | Id of the committing instruction |
| cmt_hit | output | 1 | Oldest in-flight entry matches and is complete; it is removed |
| cmt_data | output | DATA_W | Data of the oldest in-flight entry |

## Verification
The bench uses the default values: four entries in each queue, 4-bit ids, 16-bit address and data, and a write burst limit of 2. With four-deep queues, the refused push, the in-flight stall and the full-buffer commit refusal each take only a handful of operations to reach. A limit of 2 against four buffered writes shows the write, write, load, write, write grant pattern within one drain. A random phase sends sixty loads through, with random translation timing, random memory acceptance and shuffled response order. Ids wrap modulo 16 while no more than eight are in flight at once.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_STBUF = 2'd1,
    PORT_LOAD  = 2'd2
  } port_own_e;
endpackage

// File: rtl/lsq_reqq.sv
module lsq_reqq #(
  parameter int DEPTH  = 4,
  parameter int ID_W   = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_en,
  input  logic [ID_W-1:0]   push_id,
  input  logic              push_store,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              xlate_done,
  input  logic              pop_en,
  output logic              full,
  output logic              head_vld,
  output logic              head_xl,
  output logic [ID_W-1:0]   head_id,
  output logic              head_store,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [ID_W-1:0]   id_mem   [DEPTH];
  logic              st_mem   [DEPTH];
  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;
  logic              xl_q;

  // storage without reset so it can map to distributed or block RAM
  always_ff @(posedge clk) begin
    if (push_en) begin
      id_mem[wr_ptr]   <= push_id;
      st_mem[wr_ptr]   <= push_store;
      addr_mem[wr_ptr] <= push_addr;
      data_mem[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      xl_q   <= 1'b0;
    end else begin
      if (push_en) wr_ptr <= wr_ptr + PW'(1);
      if (pop_en)  rd_ptr <= rd_ptr + PW'(1);
      count <= count + CW'(push_en) - CW'(pop_en);
      // translation flag belongs to the current head only
      if (pop_en)
        xl_q <= 1'b0;
      else if (xlate_done && head_vld)
        xl_q <= 1'b1;
    end
  end

  assign full       = (count == CW'(DEPTH));
  assign head_vld   = (count != '0);
  assign head_xl    = xl_q;
  assign head_id    = id_mem[rd_ptr];
  assign head_store = st_mem[rd_ptr];
  assign head_addr  = addr_mem[rd_ptr];
  assign head_data  = data_mem[rd_ptr];

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_push_refused_R2: assert property (@(posedge clk) disable iff (rst)
    (full && !pop_en) |=> full && $stable(wr_ptr));
  assert_pop_translated_R3: assert property (@(posedge clk) disable iff (rst)
    pop_en |-> (head_vld && head_xl));
endmodule

// File: rtl/lsq_xferq.sv
module lsq_xferq #(
  parameter int DEPTH  = 4,
  parameter int ID_W   = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_en,
  input  logic [ID_W-1:0]   push_id,
  input  logic              push_store,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_done,
  input  logic              rsp_valid,
  input  logic [ID_W-1:0]   rsp_id,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              pop_en,
  output logic              full,
  output logic              head_vld,
  output logic [ID_W-1:0]   head_id,
  output logic              head_store,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic              head_done
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]  vld_q, done_q, match;
  logic [ID_W-1:0]   id_q   [DEPTH];
  logic              st_q   [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;

  // associative search of every live, still-open load slot
  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      match[i] = rsp_valid && vld_q[i] && !done_q[i] && !st_q[i] && (id_q[i] == rsp_id);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[g]  <= 1'b0;
        done_q[g] <= 1'b0;
      end else if (push_en && wr_ptr == PW'(g)) begin
        vld_q[g]  <= 1'b1;
        done_q[g] <= push_done;
      end else if (pop_en && rd_ptr == PW'(g)) begin
        vld_q[g]  <= 1'b0;
        done_q[g] <= 1'b0;
      end else if (match[g]) begin
        done_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (push_en && wr_ptr == PW'(g)) begin
        id_q[g]   <= push_id;
        st_q[g]   <= push_store;
        addr_q[g] <= push_addr;
        data_q[g] <= push_data;
      end else if (match[g]) begin
        data_q[g] <= rsp_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_en) wr_ptr <= wr_ptr + PW'(1);
      if (pop_en)  rd_ptr <= rd_ptr + PW'(1);
      count <= count + CW'(push_en) - CW'(pop_en);
    end
  end

  assign full       = (count == CW'(DEPTH));
  assign head_vld   = (count != '0);
  assign head_id    = id_q[rd_ptr];
  assign head_store = st_q[rd_ptr];
  assign head_addr  = addr_q[rd_ptr];
  assign head_data  = data_q[rd_ptr];
  assign head_done  = done_q[rd_ptr];

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    push_en |-> !full);
  assert_unique_match_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
  assert_complete_sticks_R5: assert property (@(posedge clk) disable iff (rst)
    (|match && !pop_en) |=> $countones(done_q) == $past($countones(done_q)) + 1 + $past(push_en && push_done));
  assert_head_retire_R6: assert property (@(posedge clk) disable iff (rst)
    pop_en |-> (head_vld && head_done));
endmodule

// File: rtl/lsq_stbuf.sv
module lsq_stbuf #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_en,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              drain_en,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              full,
  output logic              empty,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;

  always_ff @(posedge clk) begin
    if (push_en) begin
      addr_mem[wr_ptr] <= push_addr;
      data_mem[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_en)  wr_ptr <= wr_ptr + PW'(1);
      if (drain_en) rd_ptr <= rd_ptr + PW'(1);
      count <= count + CW'(push_en) - CW'(drain_en);
    end
  end

  // oldest-to-youngest scan; a later match overrides, so the youngest wins
  always_comb begin
    logic [PW-1:0] scan_idx;
    lk_hit  = 1'b0;
    lk_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      scan_idx = rd_ptr + PW'(i);
      if (CW'(i) < count && addr_mem[scan_idx] == lk_addr) begin
        lk_hit  = 1'b1;
        lk_data = data_mem[scan_idx];
      end
    end
  end

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign head_addr = addr_mem[rd_ptr];
  assign head_data = data_mem[rd_ptr];

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    push_en |-> !full);
  assert_no_drain_empty_R8: assert property (@(posedge clk) disable iff (rst)
    drain_en |-> !empty);
endmodule

// File: rtl/ldst_queue.sv
module ldst_queue
  import lsq_pkg::*;
#(
  parameter int RQ_DEPTH = 4,
  parameter int XQ_DEPTH = 4,
  parameter int SB_DEPTH = 4,
  parameter int ID_W     = 4,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int SB_LIMIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [ID_W-1:0]   push_id,
  input  logic              push_store,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              xlate_done,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic [ID_W-1:0]   mreq_id,
  output logic              mreq_store,
  output logic [ADDR_W-1:0] mreq_addr,
  output logic [DATA_W-1:0] mreq_data,
  input  logic              mrsp_valid,
  input  logic [ID_W-1:0]   mrsp_id,
  input  logic [DATA_W-1:0] mrsp_data,
  input  logic              cmt_valid,
  input  logic [ID_W-1:0]   cmt_id,
  output logic              cmt_hit,
  output logic [DATA_W-1:0] cmt_data
);
  localparam int BW = $clog2(SB_LIMIT + 1);

  logic              rq_full, rq_vld, rq_xl, rq_store, rq_pop, rq_push;
  logic [ID_W-1:0]   rq_id;
  logic [ADDR_W-1:0] rq_addr;
  logic [DATA_W-1:0] rq_data;

  logic              xq_full, xq_vld, xq_store, xq_done, xq_push, xq_pop, xq_push_done;
  logic [ID_W-1:0]   xq_id;
  logic [ADDR_W-1:0] xq_addr;
  logic [DATA_W-1:0] xq_data, xq_push_data;

  logic              sb_full, sb_empty, sb_push, sb_drain, sb_hit;
  logic [ADDR_W-1:0] sb_addr;
  logic [DATA_W-1:0] sb_data, sb_fwd;

  logic              head_ready, load_go, local_go, sb_sel, load_issue;
  logic [BW-1:0]     burst_q;
  port_own_e         own;

  assign rq_push = push_valid && push_ready;

  lsq_reqq #(.DEPTH(RQ_DEPTH), .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_reqq (
    .clk(clk), .rst(rst), .push_en(rq_push), .push_id(push_id), .push_store(push_store),
    .push_addr(push_addr), .push_data(push_data), .xlate_done(xlate_done), .pop_en(rq_pop),
    .full(rq_full), .head_vld(rq_vld), .head_xl(rq_xl), .head_id(rq_id),
    .head_store(rq_store), .head_addr(rq_addr), .head_data(rq_data));

  lsq_xferq #(.DEPTH(XQ_DEPTH), .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xferq (
    .clk(clk), .rst(rst), .push_en(xq_push), .push_id(rq_id), .push_store(rq_store),
    .push_addr(rq_addr), .push_data(xq_push_data), .push_done(xq_push_done),
    .rsp_valid(mrsp_valid), .rsp_id(mrsp_id), .rsp_data(mrsp_data), .pop_en(xq_pop),
    .full(xq_full), .head_vld(xq_vld), .head_id(xq_id), .head_store(xq_store),
    .head_addr(xq_addr), .head_data(xq_data), .head_done(xq_done));

  lsq_stbuf #(.DEPTH(SB_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stbuf (
    .clk(clk), .rst(rst), .push_en(sb_push), .push_addr(xq_addr), .push_data(xq_data),
    .drain_en(sb_drain), .lk_addr(rq_addr), .full(sb_full), .empty(sb_empty),
    .head_addr(sb_addr), .head_data(sb_data), .lk_hit(sb_hit), .lk_data(sb_fwd));

  // pending head is translated and has somewhere to go
  assign head_ready = rq_vld && rq_xl && !xq_full;
  assign load_go    = head_ready && !rq_store && !sb_hit;
  assign local_go   = head_ready && (rq_store || sb_hit);

  // write buffer owns the port until its burst budget is spent on a waiting load
  assign sb_sel = !sb_empty && (!load_go || burst_q < BW'(SB_LIMIT));

  always_comb begin
    if (sb_sel)       own = PORT_STBUF;
    else if (load_go) own = PORT_LOAD;
    else              own = PORT_IDLE;
  end

  assign mreq_valid = (own != PORT_IDLE);
  assign mreq_store = (own == PORT_STBUF);
  assign mreq_id    = (own == PORT_LOAD) ? rq_id : '0;
  assign mreq_addr  = (own == PORT_STBUF) ? sb_addr : rq_addr;
  assign mreq_data  = (own == PORT_STBUF) ? sb_data : '0;

  assign sb_drain   = (own == PORT_STBUF) && mreq_ready;
  assign load_issue = (own == PORT_LOAD) && mreq_ready;

  always_ff @(posedge clk) begin
    if (rst)
      burst_q <= '0;
    else if (load_issue)
      burst_q <= '0;
    else if (sb_drain && burst_q < BW'(SB_LIMIT))
      burst_q <= burst_q + BW'(1);
  end

  assign rq_pop       = load_issue || local_go;
  assign xq_push      = rq_pop;
  assign xq_push_done = local_go;
  assign xq_push_data = rq_store ? rq_data : (sb_hit ? sb_fwd : '0);

  assign push_ready = !rq_full;

  assign cmt_hit  = cmt_valid && xq_vld && xq_done && (xq_id == cmt_id) && (!xq_store || !sb_full);
  assign cmt_data = xq_data;
  assign xq_pop   = cmt_hit;
  assign sb_push  = cmt_hit && xq_store;

  assert_store_no_mem_R7: assert property (@(posedge clk) disable iff (rst)
    (mreq_valid && !mreq_store) |-> (rq_vld && !rq_store));
  assert_fwd_no_mem_R9: assert property (@(posedge clk) disable iff (rst)
    (mreq_valid && !mreq_store) |-> !sb_hit);
  assert_untranslated_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (rq_vld && !rq_xl) |-> !(mreq_valid && !mreq_store));
  assert_yield_R10: assert property (@(posedge clk) disable iff (rst)
    (load_go && burst_q >= BW'(SB_LIMIT)) |-> (mreq_valid && !mreq_store));
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (push_ready && !cmt_hit));
endmodule

// File: tb/ldst_queue_tb_top.sv
module ldst_queue_tb_top;
  localparam int ID_W = 4, ADDR_W = 16, DATA_W = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst;
  logic push_valid, push_ready, push_store, xlate_done;
  logic [ID_W-1:0]   push_id, mreq_id, mrsp_id, cmt_id;
  logic [ADDR_W-1:0] push_addr, mreq_addr;
  logic [DATA_W-1:0] push_data, mreq_data, mrsp_data, cmt_data;
  logic mreq_valid, mreq_ready, mreq_store, mrsp_valid, cmt_valid, cmt_hit;

  ldst_queue dut_i (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_ready(push_ready),
    .push_id(push_id), .push_store(push_store), .push_addr(push_addr), .push_data(push_data),
    .xlate_done(xlate_done), .mreq_valid(mreq_valid), .mreq_ready(mreq_ready),
    .mreq_id(mreq_id), .mreq_store(mreq_store), .mreq_addr(mreq_addr), .mreq_data(mreq_data),
    .mrsp_valid(mrsp_valid), .mrsp_id(mrsp_id), .mrsp_data(mrsp_data),
    .cmt_valid(cmt_valid), .cmt_id(cmt_id), .cmt_hit(cmt_hit), .cmt_data(cmt_data));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // staged drive values, applied at the falling edge
  logic d_push = 0, d_st = 0, d_xl = 0, d_mrdy = 0, d_rsp = 0, d_cmt = 0;
  logic [ID_W-1:0]   d_id = '0, d_rsp_id = '0, d_cmt_id = '0;
  logic [ADDR_W-1:0] d_addr = '0;
  logic [DATA_W-1:0] d_data = '0, d_rsp_data = '0;

  // observed outputs for the cycle just driven
  logic o_pr, o_pacc, o_mv, o_ms, o_hit;
  logic [ID_W-1:0]   o_mid;
  logic [ADDR_W-1:0] o_maddr;
  logic [DATA_W-1:0] o_mdata, o_cdata;

  // memory model for the random phase
  bit auto_mem = 0;
  int np = 0;
  logic [ID_W-1:0]   pend_id   [16];
  logic [ADDR_W-1:0] pend_addr [16];

  function automatic logic [DATA_W-1:0] mem_fn(input logic [ADDR_W-1:0] a);
    return (a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    push_valid = d_push; push_id = d_id; push_store = d_st; push_addr = d_addr; push_data = d_data;
    xlate_done = d_xl; mreq_ready = d_mrdy;
    mrsp_valid = d_rsp; mrsp_id = d_rsp_id; mrsp_data = d_rsp_data;
    cmt_valid = d_cmt; cmt_id = d_cmt_id;
    #1;
    o_pr = push_ready; o_pacc = push_valid && push_ready;
    o_mv = mreq_valid; o_ms = mreq_store; o_mid = mreq_id; o_maddr = mreq_addr; o_mdata = mreq_data;
    o_hit = cmt_hit; o_cdata = cmt_data;
    if (auto_mem && mreq_valid && mreq_ready && !mreq_store) begin
      pend_id[np] = mreq_id; pend_addr[np] = mreq_addr; np++;
    end
    d_push = 0; d_xl = 0; d_rsp = 0; d_cmt = 0;
  endtask

  task automatic push_op(input int id, input bit st, input int addr, input int data);
    d_push = 1; d_id = ID_W'(id); d_st = st; d_addr = ADDR_W'(addr); d_data = DATA_W'(data);
    cyc();
  endtask
  task automatic xl();
    d_xl = 1; cyc();
  endtask
  task automatic rsp(input int id, input int data);
    d_rsp = 1; d_rsp_id = ID_W'(id); d_rsp_data = DATA_W'(data); cyc();
  endtask
  task automatic cmt(input int id);
    d_cmt = 1; d_cmt_id = ID_W'(id); cyc();
  endtask
  task automatic issue_load(input int id, input int addr);
    push_op(id, 1'b0, addr, 0); xl();
    d_mrdy = 1; cyc(); d_mrdy = 0;
    chk("R4", "load request id", int'(o_mid), id);
  endtask
  task automatic do_store(input int id, input int addr, input int data, input bit exp_hit);
    push_op(id, 1'b1, addr, data); xl(); cyc();
    chk("R7", "store caused load request", int'(o_mv && !o_ms), 0);
    cmt(id);
    chk("R7", "store commit hit", int'(o_hit), int'(exp_hit));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1;
    cyc(); cyc();
    rst = 0;
    // R1 reset state
    cmt(0);
    chk("R1", "push_ready", int'(o_pr), 1);
    chk("R1", "mreq_valid", int'(o_mv), 0);
    chk("R1", "cmt_hit", int'(o_hit), 0);

    // R3 wait for translation, R4 issue, R5/R6 out-of-order completion
    push_op(1, 0, 'h40, 0);
    repeat (3) cyc();
    chk("R3", "request before translation", int'(o_mv), 0);
    xl();
    chk("R3", "request in translation cycle", int'(o_mv), 0);
    d_mrdy = 1; cyc(); d_mrdy = 0;
    chk("R4", "mreq_valid", int'(o_mv), 1);
    chk("R4", "mreq_store", int'(o_ms), 0);
    chk("R4", "mreq_id", int'(o_mid), 1);
    chk("R4", "mreq_addr", int'(o_maddr), 'h40);
    cyc();
    chk("R4", "load moved, port idle", int'(o_mv), 0);
    issue_load(2, 'h44);
    rsp(2, 'hBEEF);
    cmt(2);
    chk("R6", "complete non-head query", int'(o_hit), 0);
    cmt(1);
    chk("R5", "incomplete head query", int'(o_hit), 0);
    rsp(1, 'h1234);
    cmt(1);
    chk("R5", "head hit", int'(o_hit), 1);
    chk("R5", "head data", int'(o_cdata), 'h1234);
    cmt(2);
    chk("R5", "second hit", int'(o_hit), 1);
    chk("R5", "second data", int'(o_cdata), 'hBEEF);
    cmt(2);
    chk("R6", "query on empty queue", int'(o_hit), 0);

    // R3 translation pulse on empty queue ignored
    xl();
    push_op(3, 0, 'h48, 0);
    d_mrdy = 1; cyc(); d_mrdy = 0;
    chk("R3", "stale translation ignored", int'(o_mv), 0);
    xl();
    d_mrdy = 1; cyc(); d_mrdy = 0;
    chk("R3", "issue after translation", int'(o_mid), 3);
    rsp(3, 'h3333); cmt(3);
    chk("R5", "id3 data", int'(o_cdata), 'h3333);

    // R2 full pending queue refuses push
    for (int i = 0; i < 4; i++) begin
      push_op(4 + i, 0, 'h50 + 2 * i, 0);
      chk("R2", "push accepted", int'(o_pr), 1);
    end
    push_op(8, 0, 'h5E, 0);
    chk("R2", "push refused when full", int'(o_pr), 0);
    for (int i = 0; i < 4; i++) begin
      xl(); d_mrdy = 1; cyc(); d_mrdy = 0;
      chk("R2", "drain order id", int'(o_mid), 4 + i);
    end
    xl(); d_mrdy = 1; cyc(); d_mrdy = 0;
    chk("R2", "refused push left nothing", int'(o_mv), 0);
    for (int i = 0; i < 4; i++) begin
      rsp(4 + i, mem_fn(16'('h50 + 2 * i)));
      cmt(4 + i);
      chk("R5", "id4..7 data", int'(o_cdata), int'(mem_fn(16'('h50 + 2 * i))));
    end

    // R4 in-flight queue full stalls the move
    for (int i = 0; i < 4; i++) issue_load(9 + i, 'h60 + 2 * i);
    push_op(13, 0, 'h70, 0); xl();
    d_mrdy = 1; cyc();
    chk("R4", "stall while in-flight full", int'(o_mv), 0);
    rsp(9, 'h0909); cmt(9);
    chk("R4", "head commit frees slot", int'(o_hit), 1);
    cyc(); d_mrdy = 0;
    chk("R4", "stalled load issues", int'(o_mv && !o_ms && o_mid == 13), 1);
    for (int i = 10; i < 14; i++) begin
      rsp(i, i * 3); cmt(i);
      chk("R5", "id10..13 data", int'(o_cdata), i * 3);
    end

    // R7/R9 stores, forwarding, full write buffer
    d_mrdy = 0;
    do_store(1, 'h100, 'hA1, 1);
    do_store(2, 'h104, 'hA2, 1);
    do_store(3, 'h100, 'hA3, 1);
    push_op(4, 0, 'h100, 0); xl(); cyc();
    chk("R9", "forwarded load requested memory", int'(o_mv && !o_ms), 0);
    cmt(4);
    chk("R9", "forwarded hit", int'(o_hit), 1);
    chk("R9", "youngest store data", int'(o_cdata), 'hA3);
    do_store(5, 'h108, 'hA4, 1);
    do_store(6, 'h10C, 'hA5, 0);
    push_op(7, 0, 'h200, 0); xl();

    // R8 drain order and R10 burst limit
    d_mrdy = 1;
    cyc();
    chk("R8", "first write", int'({o_ms, o_maddr}), int'({1'b1, 16'h100}));
    chk("R8", "first data", int'(o_mdata), 'hA1);
    cyc();
    chk("R8", "second write", int'({o_ms, o_maddr}), int'({1'b1, 16'h104}));
    chk("R8", "second data", int'(o_mdata), 'hA2);
    cyc();
    chk("R10", "load after burst", int'({o_mv, o_ms, o_mid}), int'({1'b1, 1'b0, 4'd7}));
    chk("R10", "load addr", int'(o_maddr), 'h200);
    cyc();
    chk("R8", "third write", int'({o_ms, o_maddr}), int'({1'b1, 16'h100}));
    chk("R8", "third data", int'(o_mdata), 'hA3);
    cyc();
    chk("R8", "fourth write", int'({o_ms, o_maddr}), int'({1'b1, 16'h108}));
    cyc();
    chk("R8", "buffer empty", int'(o_mv), 0);
    cmt(6);
    chk("R7", "store commit after room", int'(o_hit), 1);
    cyc();
    chk("R7", "committed store written", int'({o_mv, o_ms, o_maddr}), int'({1'b1, 1'b1, 16'h10C}));
    chk("R7", "committed store data", int'(o_mdata), 'hA5);
    d_mrdy = 0;
    rsp(7, 'h7777); cmt(7);
    chk("R5", "load id7 data", int'(o_cdata), 'h7777);

    // random phase: loads with random translation, acceptance and response order
    begin
      logic [ID_W-1:0]   exp_id   [60];
      logic [ADDR_W-1:0] exp_addr [60];
      logic [ADDR_W-1:0] try_addr;
      int k = 0, c = 0;
      auto_mem = 1; np = 0;
      for (int t = 0; t < 6000 && c < 60; t++) begin
        try_addr = ADDR_W'($urandom_range(0, 255)) << 1;
        if (k < 60 && ($urandom % 2) == 1) begin
          d_push = 1; d_id = ID_W'(k % 16); d_st = 0; d_addr = try_addr; d_data = '0;
        end
        d_xl = ($urandom % 2) == 1;
        d_mrdy = ($urandom % 2) == 1;
        if (np > 0 && ($urandom % 3) == 0) begin
          int j = int'($urandom % np);
          d_rsp = 1; d_rsp_id = pend_id[j]; d_rsp_data = mem_fn(pend_addr[j]);
          pend_id[j] = pend_id[np - 1]; pend_addr[j] = pend_addr[np - 1]; np--;
        end
        if (c < k) begin d_cmt = 1; d_cmt_id = exp_id[c]; end
        cyc();
        if (o_pacc) begin exp_id[k] = ID_W'(k % 16); exp_addr[k] = try_addr; k++; end
        if (o_hit) begin
          chk("R5", "random load data", int'(o_cdata), int'(mem_fn(exp_addr[c])));
          c++;
        end
      end
      chk("R5", "random loads committed", c, 60);
      auto_mem = 0; d_mrdy = 0;
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule